// File: doc/BRIEF.md
# Handshake Instruction Sequencer

This block decodes and sequences instructions for a small processor. The fetch unit presents a two-bit opcode and raises a decode request. The block then works through the datapath steps that the instruction needs. Each step is a four-phase request/acknowledge exchange with one datapath unit: the register-file read port, the register-file write port, the ALU, the data-memory read port, the data-memory write port, or the program-counter load path. When the last exchange is complete, the block acknowledges the fetch unit. Every instruction ends with the same return-to-zero exchange on that request/acknowledge pair.

The ALU zero flag is read only for a conditional branch, and only in the cycle the request is accepted. A branch whose zero flag is low needs no datapath work, so the block acknowledges it at once. The controller is a clocked FSM. All request outputs and the fetch acknowledge come straight from flops.

Top module: `insn_seq_ctrl`

## Requirements
- R1: After reset, every datapath request and the fetch acknowledge are low.
- R2: Opcode 00 is arithmetic. It runs a register-file read, then an ALU exchange, then a register-file write, then the fetch acknowledge.
- R3: Opcode 10 is load. It runs a register-file read, then a data-memory read, then a register-file write.
- R4: Opcode 11 is store. It runs a register-file read, then a data-memory write.
- R5: Opcode 01 is branch. When the zero flag is high at acceptance, it runs exactly one program-counter load exchange.
- R6: A branch with the zero flag low at acceptance raises no datapath request. The fetch acknowledge is high in the cycle after acceptance.
- R7: Every exchange is four-phase:
  - A request stays high until its acknowledge is seen high.
  - The request falls on the clock edge after the acknowledge is seen high.
  - The next request rises only after the previous acknowledge is seen low.
  - At most one datapath request is high at a time.
  - The first request rises one cycle after the decode request is accepted.
- R8: The fetch acknowledge rises one cycle after the last datapath acknowledge is seen low. It stays high while the decode request is high and falls one cycle after the decode request is seen low. No datapath request is high while it is high.
- R9: The zero flag has no effect on any instruction other than branch. For a branch, changes after the accepting edge have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_req | input | 1 | Decode request from fetch |
| opc | input | 2 | Opcode; must be held while dec_req is high |
| alu_zero | input | 1 | ALU zero-result flag |
| dec_ack | output | 1 | Decode acknowledge to fetch |
| rf_rd_req | output | 1 | Register-file read request |
| rf_rd_ack | input | 1 | Register-file read acknowledge |
| rf_wr_req | output | 1 | Register-file write request |
| rf_wr_ack | input | 1 | Register-file write acknowledge |
| alu_req | output | 1 | ALU request |
| alu_ack | input | 1 | ALU acknowledge |
| mem_rd_req | output | 1 | Data-memory read request |
| mem_rd_ack | input | 1 | Data-memory read acknowledge |
| mem_wr_req | output | 1 | Data-memory write request |
| mem_wr_ack | input | 1 | Data-memory write acknowledge |
| pc_ld_req | output | 1 | Program-counter load request |
| pc_ld_ack | input | 1 | Program-counter load acknowledge |

## Verification
The bench runs the following cases:
- A not-taken branch. A design that still sends a datapath request, or that adds a cycle before acknowledging, fails here.
- A taken branch. A design that skips the program-counter exchange fails here.
- The zero flag toggling on every cycle after acceptance. A design that reads the flag late, or reads it for other instructions, picks the wrong path or changes its step count.
- Different acknowledge latencies per unit, including zero-delay responders. These expose a design that moves to the next step before the previous acknowledge has fallen, or that holds two requests at once.
- Back-to-back instructions. These catch a controller that accepts a new request while its fetch acknowledge is still high.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int N_UNITS = 6;
  localparam int UNIT_W  = $clog2(N_UNITS);
  localparam int MAX_STEPS = 3;
  localparam int IDX_W   = $clog2(MAX_STEPS + 1);

  typedef enum logic [UNIT_W-1:0] {
    U_RFRD = 3'd0, U_RFWR = 3'd1, U_ALU = 3'd2,
    U_MRD  = 3'd3, U_MWR  = 3'd4, U_PC  = 3'd5
  } unit_e;

  typedef enum logic [1:0] {
    OP_ARITH = 2'b00, OP_BRANCH = 2'b01, OP_LOAD = 2'b10, OP_STORE = 2'b11
  } opc_e;

  // number of datapath exchanges an instruction needs
  function automatic logic [IDX_W-1:0] seq_len(opc_e op, logic z);
    case (op)
      OP_ARITH:  seq_len = IDX_W'(3);
      OP_LOAD:   seq_len = IDX_W'(3);
      OP_STORE:  seq_len = IDX_W'(2);
      default:   seq_len = z ? IDX_W'(1) : IDX_W'(0);
    endcase
  endfunction

  // unit addressed by step number idx of an instruction
  function automatic unit_e seq_unit(opc_e op, logic [IDX_W-1:0] idx);
    seq_unit = U_RFRD;
    case (op)
      OP_ARITH:  seq_unit = (idx == 0) ? U_RFRD : (idx == 1) ? U_ALU : U_RFWR;
      OP_LOAD:   seq_unit = (idx == 0) ? U_RFRD : (idx == 1) ? U_MRD : U_RFWR;
      OP_STORE:  seq_unit = (idx == 0) ? U_RFRD : U_MWR;
      default:   seq_unit = U_PC;
    endcase
  endfunction
endpackage

// File: rtl/isc_opdec.sv
module isc_opdec
  import isc_pkg::*;
(
  input  logic [1:0]       op,
  input  logic             z,
  input  logic [IDX_W-1:0] idx,
  output logic [UNIT_W-1:0] unit,
  output logic [IDX_W-1:0] len
);
  opc_e op_e;
  always_comb begin
    op_e = opc_e'(op);
    len  = seq_len(op_e, z);
    unit = seq_unit(op_e, idx);
  end
endmodule

// File: rtl/isc_req_bank.sv
module isc_req_bank
  import isc_pkg::*;
#(
  parameter int N = N_UNITS,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_req,
  input  logic          clr_req,
  input  logic [SW-1:0] sel,
  input  logic [N-1:0]  ack,
  output logic [N-1:0]  req
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    wire hit = (sel == SW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)                req[i] <= 1'b0;
      else if (set_req && hit)   req[i] <= 1'b1;
      else if (clr_req && hit)   req[i] <= 1'b0;
    end

    // R7: a raised request holds until its acknowledge arrives
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req[i] && !ack[i]) |=> req[i]);
    // R7: a request only falls after its acknowledge was seen
    p_req_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req[i] && ack[i]) |=> !req[i]);
  end
endmodule

// File: rtl/isc_seq.sv
module isc_seq
  import isc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_req,
  input  logic [1:0]        op_in,
  input  logic              z_in,
  input  logic              cur_ack,
  input  logic [UNIT_W-1:0] dec_unit,
  input  logic [IDX_W-1:0]  dec_len,
  output logic [1:0]        eff_op,
  output logic              eff_z,
  output logic [IDX_W-1:0]  dec_idx,
  output logic              set_req,
  output logic              clr_req,
  output logic [UNIT_W-1:0] sel,
  output logic [UNIT_W-1:0] cur_unit,
  output logic              dec_ack
);
  typedef enum logic [1:0] {S_IDLE, S_UP, S_DOWN, S_DONE} st_e;
  st_e              st;
  logic [1:0]       op_q;
  logic             z_q;
  logic [IDX_W-1:0] idx;

  wire accept_evt  = (st == S_IDLE) && dec_req;
  wire ack_seen    = (st == S_UP) && cur_ack;
  wire hs_done_evt = (st == S_DOWN) && !cur_ack;
  wire seq_end     = (dec_idx == dec_len);

  always_comb begin
    eff_op  = (st == S_IDLE) ? op_in : op_q;
    eff_z   = (st == S_IDLE) ? z_in  : z_q;
    dec_idx = (st == S_IDLE) ? '0 : (st == S_DOWN) ? idx + 1'b1 : idx;
    set_req = (accept_evt || hs_done_evt) && !seq_end;
    clr_req = ack_seen;
    sel     = set_req ? dec_unit : cur_unit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= '0; z_q <= 1'b0; idx <= '0;
      cur_unit <= '0; dec_ack <= 1'b0;
    end else begin
      if (set_req) cur_unit <= dec_unit;
      case (st)
        S_IDLE: if (accept_evt) begin
          op_q <= op_in; z_q <= z_in; idx <= '0;
          if (seq_end) begin st <= S_DONE; dec_ack <= 1'b1; end
          else st <= S_UP;
        end
        S_UP:   if (ack_seen) st <= S_DOWN;
        S_DOWN: if (hs_done_evt) begin
          idx <= dec_idx;
          if (seq_end) begin st <= S_DONE; dec_ack <= 1'b1; end
          else st <= S_UP;
        end
        default: if (!dec_req) begin st <= S_IDLE; dec_ack <= 1'b0; end
      endcase
    end
  end

  // R6: a branch with the flag low is acknowledged in the next cycle
  p_skip_branch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && op_in == OP_BRANCH && !z_in) |=> dec_ack);
  // R8: the fetch acknowledge holds while the decode request stays high
  p_ack_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_ack && dec_req) |=> dec_ack);
  // R8: the fetch acknowledge falls once the decode request has dropped
  p_ack_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_ack && !dec_req) |=> !dec_ack);
endmodule

// File: rtl/insn_seq_ctrl.sv
module insn_seq_ctrl
  import isc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dec_req,
  input  logic [1:0] opc,
  input  logic       alu_zero,
  output logic       dec_ack,
  output logic       rf_rd_req,
  input  logic       rf_rd_ack,
  output logic       rf_wr_req,
  input  logic       rf_wr_ack,
  output logic       alu_req,
  input  logic       alu_ack,
  output logic       mem_rd_req,
  input  logic       mem_rd_ack,
  output logic       mem_wr_req,
  input  logic       mem_wr_ack,
  output logic       pc_ld_req,
  input  logic       pc_ld_ack
);
  logic [N_UNITS-1:0] ack_vec, req_vec;
  logic [1:0]         eff_op;
  logic               eff_z, set_req, clr_req;
  logic [IDX_W-1:0]   dec_idx, dec_len;
  logic [UNIT_W-1:0]  dec_unit, sel, cur_unit;
  logic               cur_ack;

  assign ack_vec = {pc_ld_ack, mem_wr_ack, mem_rd_ack, alu_ack, rf_wr_ack, rf_rd_ack};
  assign cur_ack = ack_vec[cur_unit];
  assign {pc_ld_req, mem_wr_req, mem_rd_req, alu_req, rf_wr_req, rf_rd_req} = req_vec;

  isc_opdec u_dec (
    .op(eff_op), .z(eff_z), .idx(dec_idx), .unit(dec_unit), .len(dec_len)
  );

  isc_seq u_seq (
    .clk, .rst_n, .dec_req, .op_in(opc), .z_in(alu_zero), .cur_ack,
    .dec_unit, .dec_len, .eff_op, .eff_z, .dec_idx, .set_req, .clr_req,
    .sel, .cur_unit, .dec_ack
  );

  isc_req_bank #(.N(N_UNITS)) u_bank (
    .clk, .rst_n, .set_req, .clr_req, .sel, .ack(ack_vec), .req(req_vec)
  );

  // R7: never more than one datapath exchange in flight
  p_onehot_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_vec));
  // R8: datapath is quiet while fetch is being acknowledged
  p_quiet_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_ack |-> (req_vec == '0));
  // R1: outputs low in the first cycle after reset
  p_reset_low_r1: assert property (@(posedge clk)
    !rst_n |=> (req_vec == '0 && !dec_ack));
endmodule

// File: tb/insn_seq_ctrl_test.sv
module insn_seq_ctrl_test;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic dec_req = 0, alu_zero = 0;
  logic [1:0] opc = 0;
  logic dec_ack;
  logic [5:0] req, ack = 0;   // order: rf_rd, rf_wr, alu, mem_rd, mem_wr, pc

  insn_seq_ctrl uut (
    .clk, .rst_n, .dec_req, .opc, .alu_zero, .dec_ack,
    .rf_rd_req(req[0]), .rf_rd_ack(ack[0]),
    .rf_wr_req(req[1]), .rf_wr_ack(ack[1]),
    .alu_req(req[2]),   .alu_ack(ack[2]),
    .mem_rd_req(req[3]), .mem_rd_ack(ack[3]),
    .mem_wr_req(req[4]), .mem_wr_ack(ack[4]),
    .pc_ld_req(req[5]), .pc_ld_ack(ack[5])
  );

  int checks = 0, errors = 0;
  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: queue of pending exchanges
  int m_ph = 0;            // 0 wait, 1 req high, 2 req low, 3 answering fetch
  int m_q[$];
  function automatic void plan(int op, bit z, ref int q[$]);
    q = {};
    if (op == 0) q = {0, 2, 1};
    else if (op == 2) q = {0, 3, 1};
    else if (op == 3) q = {0, 4};
    else if (z) q = {5};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin m_ph = 0; m_q = {}; end
    else case (m_ph)
      0: if (dec_req) begin plan(opc, alu_zero, m_q); m_ph = (m_q.size() == 0) ? 3 : 1; end
      1: if (ack[m_q[0]]) m_ph = 2;
      2: if (!ack[m_q[0]]) begin void'(m_q.pop_front()); m_ph = (m_q.size() == 0) ? 3 : 1; end
      default: if (!dec_req) m_ph = 0;
    endcase
  end

  // responders and fetch driver
  int lat[6] = '{0, 0, 0, 0, 0, 0};
  int cnt[6] = '{0, 0, 0, 0, 0, 0};
  int rises[6];
  logic [5:0] req_prev = 0;
  bit z_wiggle = 0;
  int prog_op[$];
  bit prog_z[$];
  int f_st = 0, wait_cyc = 0, cur_op = 0;
  bit cur_z = 0;

  function automatic string tag_of(int op, bit z);
    if (op == 0) return "R2";
    if (op == 2) return "R3";
    if (op == 3) return "R4";
    return z ? "R5" : "R6";
  endfunction

  always @(negedge clk) if (rst_n) begin
    logic [5:0] exp_req;
    exp_req = (m_ph == 1) ? 6'(1 << m_q[0]) : 6'b0;
    chk(req == exp_req, "R7 request vector", int'(req), int'(exp_req));
    chk(dec_ack == (m_ph == 3), "R8 fetch acknowledge", int'(dec_ack), int'(m_ph == 3));
    for (int i = 0; i < 6; i++) if (req[i] && !req_prev[i]) rises[i]++;
    req_prev = req;
    for (int i = 0; i < 6; i++) begin
      if (req[i] != ack[i]) begin
        if (cnt[i] >= lat[i]) begin ack[i] = req[i]; cnt[i] = 0; end
        else cnt[i]++;
      end else cnt[i] = 0;
    end
    case (f_st)
      0: if (prog_op.size() != 0 && !dec_ack) begin
        cur_op = prog_op.pop_front(); cur_z = prog_z.pop_front();
        opc = 2'(cur_op); alu_zero = cur_z; dec_req = 1;
        for (int i = 0; i < 6; i++) rises[i] = 0;
        wait_cyc = 0; f_st = 1;
      end
      1: begin
        wait_cyc++;
        if (z_wiggle) alu_zero = ~alu_zero;   // R9: flag noise after acceptance
        if (dec_ack) begin
          int e[6];
          string t;
          e = '{0, 0, 0, 0, 0, 0};
          if (cur_op == 0) e = '{1, 1, 1, 0, 0, 0};
          else if (cur_op == 2) e = '{1, 1, 0, 1, 0, 0};
          else if (cur_op == 3) e = '{1, 0, 0, 0, 1, 0};
          else if (cur_z) e = '{0, 0, 0, 0, 0, 1};
          t = tag_of(cur_op, cur_z);
          if (z_wiggle) t = {t, "/R9"};
          for (int i = 0; i < 6; i++)
            chk(rises[i] == e[i], {t, " handshake count"}, rises[i], e[i]);
          if (cur_op == 1 && !cur_z)
            chk(wait_cyc == 1, "R6 immediate acknowledge latency", wait_cyc, 1);
          dec_req = 0; f_st = 2;
        end
      end
      default: if (!dec_ack) f_st = 0;
    endcase
  end

  task automatic run(int op, bit z);
    prog_op.push_back(op); prog_z.push_back(z);
  endtask
  task automatic drain();
    while (prog_op.size() != 0 || f_st != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req == 0, "R1 requests after reset", int'(req), 0);
    chk(dec_ack == 0, "R1 acknowledge after reset", int'(dec_ack), 0);
    rst_n = 1;
    // fast responders
    run(0, 0); run(1, 0); run(1, 1); run(2, 1); run(3, 0); drain();
    // slow, uneven responders
    lat = '{2, 4, 1, 3, 5, 2};
    run(2, 0); run(3, 1); run(0, 1); run(1, 1); run(1, 0); drain();
    // flag toggling after acceptance
    z_wiggle = 1;
    run(0, 0); run(1, 1); run(1, 0); run(2, 1); run(3, 1); drain();
    lat = '{0, 1, 0, 1, 0, 1};
    for (int k = 0; k < 20; k++) run(k % 4, k[2]);
    drain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule